// File: doc/BRIEF.md
# I2C Bus Master with Programmable Data Hold

This block drives an I2C bus as its only master. A small command port accepts four operations: START, STOP, WRITE of one byte, and READ of one byte. READ also carries the acknowledge choice for the ninth bit. The block turns each command into open-drain activity on the clock and data lines and reports completion with a one-cycle done pulse.

Some targets see a data change that lands on the same clock as the SCL falling edge as a START condition, and then do not acknowledge their address. To avoid this, the master waits a programmable number of system clocks after every SCL fall before it updates SDA. A hold value of zero gives the older same-clock behaviour. The SCL period is set in system clocks, and its high and low phases are each half of that count. Before any START that follows bus activity, both lines are kept released for at least a parameter-given minimum number of clocks. At 100 MHz the default of 60 clocks is 600 ns.

Command codes on `cmd_op`: 0 = START, 1 = STOP, 2 = WRITE, 3 = READ. There is no clock stretching and no arbitration.

Top module: `i2c_hold_master`

## Requirements
- R1: In reset and after reset, both lines are released (`scl_oe`=0, `sda_oe`=0), and `busy` and `done` are 0.
- R2: START from an idle bus pulls SDA low while SCL is released. SCL then falls exactly H clocks later, where H = `cfg_period`>>1.
- R3: SDA changes while SCL is released only as a START (SDA falling) or as a STOP (SDA rising). No data or acknowledge bit changes SDA while SCL is high.
- R4: Every SDA update inside a byte or before a condition appears exactly `cfg_hold` clocks after the SCL fall that opens its slot. A hold of 0 changes SDA in the same clock as the fall. `cfg_hold` must be below H.
- R5: During a byte, each SCL low phase and each SCL high phase lasts exactly H clocks.
- R6: WRITE sends `cmd_data` MSB first on 8 clocks. On the ninth clock the master releases SDA and samples it at the rising edge: high sets `nack` to 1, low sets it to 0.
- R7: READ keeps SDA released for 8 clocks and shifts the line in MSB first into `rd_data`. On the ninth clock SDA is pulled low when `cmd_nack`=0 (ACK) and released when `cmd_nack`=1 (NACK).
- R8: A START issued while SCL is held low first releases SDA and then SCL. It keeps both released for max(H, RS_MIN) clocks before SDA falls.
- R9: STOP brings SDA low while SCL is low, then releases SCL. SDA is released H clocks later, and both lines then stay released.
- R10: A command is taken only when `busy` is 0, and `busy` is 1 from the next cycle. `done` is a one-cycle pulse with `busy` already 0. A `cmd_valid` while busy has no effect on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_period | input | PER_W | SCL period in system clocks |
| cfg_hold | input | HOLD_W | Clocks from SCL fall to SDA update |
| cmd_valid | input | 1 | Command request, taken when not busy |
| cmd_op | input | 2 | 0 START, 1 STOP, 2 WRITE, 3 READ |
| cmd_data | input | 8 | Byte to write |
| cmd_nack | input | 1 | READ: 1 answers NACK, 0 answers ACK |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Byte received by the last READ |
| nack | output | 1 | Last WRITE was not acknowledged |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | SDA line level read back |

## Verification
Written bytes are chosen with several adjacent bit changes (0xA6, 0x3C, 0x55, 0x0F, 0x81), so that the measured SCL-fall-to-SDA-change distance is taken many times. A byte of constant bits would hide a wrong hold count. Reads use 0x5A and 0xC3 with both acknowledge answers, which separates data bit ordering from ninth-bit drive. The target acknowledges one write and refuses another, so a stuck `nack` shows up. Two configurations, a short period with hold 3 and a 400 kHz period with hold 6, plus a run with hold 0, separate the phase-length arithmetic from the repeated-START minimum and from the same-clock case.

// File: rtl/i2c_hm_pkg.sv
package i2c_hm_pkg;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    K_BIT  = 2'd0,
    K_RS   = 2'd1,
    K_STOP = 2'd2
  } kind_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SHOLD  = 3'd1,
    ST_LOW    = 3'd2,
    ST_BHIGH  = 3'd3,
    ST_RSHIGH = 3'd4,
    ST_PHIGH  = 3'd5,
    ST_PFREE  = 3'd6
  } st_e;

  // half of the SCL period: length of each SCL phase
  function automatic int unsigned half_of(input int unsigned per);
    return per >> 1;
  endfunction

  // released-bus time before a START: the longer of a phase and the floor
  function automatic int unsigned rs_len_of(input int unsigned half,
                                            input int unsigned floor_clk);
    return (half > floor_clk) ? half : floor_clk;
  endfunction

  // drive-low value of SDA for a slot; idx 0..7 data bits, 8 = ninth bit
  function automatic logic sda_drive(input kind_e kind, input logic rd,
                                     input logic [3:0] idx, input logic [7:0] tx,
                                     input logic nack_sel);
    logic v;
    case (kind)
      K_RS:    v = 1'b0;
      K_STOP:  v = 1'b1;
      default: begin
        if (idx < 4'd8) v = rd ? 1'b0 : ~tx[~idx[2:0]];
        else            v = rd ? ~nack_sel : 1'b0;
      end
    endcase
    return v;
  endfunction

endpackage

// File: rtl/i2c_hm_timer.sv
module i2c_hm_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/i2c_hm_rx_shift.sv
module i2c_hm_rx_shift #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_en,
  input  logic          bit_in,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= '0;
    else if (shift_en) q <= {q[DW-2:0], bit_in};
  end
endmodule

// File: rtl/i2c_hold_master.sv
module i2c_hold_master
  import i2c_hm_pkg::*;
#(
  parameter int PER_W  = 16,
  parameter int HOLD_W = 8,
  parameter int RS_MIN = 60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PER_W-1:0]  cfg_period,
  input  logic [HOLD_W-1:0] cfg_hold,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [7:0]        cmd_data,
  input  logic              cmd_nack,
  output logic              busy,
  output logic              done,
  output logic [7:0]        rd_data,
  output logic              nack,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic              sda_in
);
  localparam int CW = PER_W;

  st_e        state;
  kind_e      kind;
  logic       rd_q, nsel_q, scl_q, sda_q, done_q, nack_q;
  logic [7:0] tx_q;
  logic [3:0] bitn;

  logic [CW-1:0] cnt, half_c, hold_c, rs_c, ph_len;
  logic restart, ph_last, accept, hold_zero, low_upd;
  op_e   op;
  kind_e entry_kind;

  // named events, also observed by the checker
  logic sda_upd_ev, smp_ev, rx_slot, cond_ev, bit_next;

  assign op         = op_e'(cmd_op);
  assign half_c     = CW'(half_of(32'(cfg_period)));
  assign hold_c     = CW'(cfg_hold);
  assign rs_c       = CW'(rs_len_of(32'(half_c), RS_MIN));
  assign hold_zero  = (hold_c == '0);
  assign accept     = (state == ST_IDLE) && cmd_valid;
  assign entry_kind = (op == OP_START) ? K_RS : (op == OP_STOP) ? K_STOP : K_BIT;

  always_comb begin
    case (state)
      ST_RSHIGH, ST_PFREE: ph_len = rs_c;
      default:             ph_len = half_c;
    endcase
  end

  assign ph_last  = (state != ST_IDLE) && (cnt == ph_len - 1'b1);
  assign restart  = (state == ST_IDLE) || ph_last;
  assign low_upd  = (state == ST_LOW) && !hold_zero && (cnt == hold_c - 1'b1);
  assign bit_next = (state == ST_BHIGH) && ph_last && (bitn != 4'd8);

  assign sda_upd_ev = low_upd ||
                      (hold_zero && bit_next) ||
                      (hold_zero && accept && !(op == OP_START && !scl_q));
  assign smp_ev  = (state == ST_BHIGH) && (cnt == '0);
  assign rx_slot = smp_ev && (rd_q ? (bitn < 4'd8) : (bitn == 4'd8));
  assign cond_ev = (accept && op == OP_START && !scl_q) ||
                   ((state == ST_RSHIGH) && ph_last) ||
                   ((state == ST_PHIGH) && ph_last);

  i2c_hm_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(restart), .cnt(cnt)
  );

  i2c_hm_rx_shift #(.DW(8)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .shift_en(smp_ev && rd_q && (bitn < 4'd8)),
    .bit_in(sda_in), .q(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      kind   <= K_BIT;
      rd_q   <= 1'b0;
      nsel_q <= 1'b0;
      tx_q   <= '0;
      bitn   <= '0;
      scl_q  <= 1'b0;
      sda_q  <= 1'b0;
      done_q <= 1'b0;
      nack_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: if (cmd_valid) begin
          rd_q   <= (op == OP_READ);
          nsel_q <= cmd_nack;
          tx_q   <= cmd_data;
          bitn   <= '0;
          kind   <= entry_kind;
          if (op == OP_WRITE) nack_q <= 1'b0;
          if (op == OP_START && !scl_q) begin
            sda_q <= 1'b1;
            state <= ST_SHOLD;
          end else begin
            scl_q <= 1'b1;
            state <= ST_LOW;
            if (hold_zero)
              sda_q <= sda_drive(entry_kind, op == OP_READ, 4'd0, cmd_data, cmd_nack);
          end
        end
        ST_SHOLD: if (ph_last) begin
          scl_q  <= 1'b1;
          state  <= ST_IDLE;
          done_q <= 1'b1;
        end
        ST_LOW: begin
          if (low_upd) sda_q <= sda_drive(kind, rd_q, bitn, tx_q, nsel_q);
          if (ph_last) begin
            scl_q <= 1'b0;
            case (kind)
              K_RS:    state <= ST_RSHIGH;
              K_STOP:  state <= ST_PHIGH;
              default: state <= ST_BHIGH;
            endcase
          end
        end
        ST_BHIGH: begin
          if (smp_ev && !rd_q && bitn == 4'd8) nack_q <= sda_in;
          if (ph_last) begin
            scl_q <= 1'b1;
            if (bitn == 4'd8) begin
              state  <= ST_IDLE;
              done_q <= 1'b1;
            end else begin
              bitn  <= bitn + 1'b1;
              state <= ST_LOW;
              if (hold_zero) sda_q <= sda_drive(kind, rd_q, bitn + 1'b1, tx_q, nsel_q);
            end
          end
        end
        ST_RSHIGH: if (ph_last) begin
          sda_q <= 1'b1;
          state <= ST_SHOLD;
        end
        ST_PHIGH: if (ph_last) begin
          sda_q <= 1'b0;
          state <= ST_PFREE;
        end
        ST_PFREE: if (ph_last) begin
          state  <= ST_IDLE;
          done_q <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy   = (state != ST_IDLE);
  assign done   = done_q;
  assign nack   = nack_q;
  assign scl_oe = scl_q;
  assign sda_oe = sda_q;

endmodule

// File: rtl/i2c_hm_checker.sv
module i2c_hm_checker #(
  parameter int RS_MIN = 60,
  parameter int HW     = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_oe,
  input logic          sda_oe,
  input logic          busy,
  input logic          done,
  input logic          cmd_valid,
  input logic [HW-1:0] cfg_hold,
  input logic          cond_ev,
  input logic          sda_upd_ev,
  input logic          rx_slot
);
  logic [15:0] lo_cnt, hi_cnt;

  // clocks since SCL was pulled low, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              lo_cnt <= '0;
    else if (!scl_oe)        lo_cnt <= '0;
    else if (lo_cnt != '1)   lo_cnt <= lo_cnt + 1'b1;
  end

  // clocks with both lines released, saturating at the floor
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         hi_cnt <= 16'(RS_MIN);
    else if (scl_oe || sda_oe)          hi_cnt <= '0;
    else if (hi_cnt < 16'(RS_MIN))      hi_cnt <= hi_cnt + 1'b1;
  end

  AST_SDA_HIGH_ONLY_COND: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && $past(!scl_oe) && (sda_oe != $past(sda_oe))) |-> $past(cond_ev)); // R3

  AST_HOLD_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_oe && (sda_oe != $past(sda_oe))) |-> (lo_cnt >= 16'(cfg_hold))); // R4

  AST_SDA_ON_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_oe && (sda_oe != $past(sda_oe))) |-> $past(sda_upd_ev)); // R4

  AST_LISTEN_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    rx_slot |-> !sda_oe); // R6

  AST_RS_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe) && !scl_oe) |-> (hi_cnt >= 16'(RS_MIN))); // R8

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_valid) |=> busy); // R10

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

endmodule

bind i2c_hold_master i2c_hm_checker #(.RS_MIN(RS_MIN), .HW(HOLD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .busy(busy), .done(done), .cmd_valid(cmd_valid), .cfg_hold(cfg_hold),
  .cond_ev(cond_ev), .sda_upd_ev(sda_upd_ev), .rx_slot(rx_slot)
);

// File: tb/test_i2c_hold_master.sv
module test_i2c_hold_master;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] cfg_period = 16'd40;
  logic [7:0]  cfg_hold = 8'd3;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [7:0] cmd_data = 8'd0;
  logic cmd_nack = 1'b0;
  logic busy, done, nack, scl_oe, sda_oe, sda_in;
  logic [7:0] rd_data;
  logic tgt_oe = 1'b0;

  assign sda_in = ~(sda_oe | tgt_oe);

  always #5 clk = ~clk;

  i2c_hold_master i_i2c_hold_master (
    .clk(clk), .rst_n(rst_n), .cfg_period(cfg_period), .cfg_hold(cfg_hold),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data), .cmd_nack(cmd_nack),
    .busy(busy), .done(done), .rd_data(rd_data), .nack(nack),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_in)
  );

  int checks = 0, fails = 0;
  int cyc = 0;
  bit finished = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // bus monitor, sampled away from the active edge
  logic p_scl = 1'b1, p_sda = 1'b1, p_moe = 1'b0, s_pend = 1'b0;
  logic [8:0] mon_sh = '0;
  int t_fall = 0, t_rise = 0, t_both = 0, t_sst = 0;
  int last_low = 0, last_high = 0, min_hold = 9999;
  int n_start = 0, n_stop = 0, last_setup = 0, stop_setup = 0, s2f = 0;
  logic last_busy_after, last_done_after;

  always @(negedge clk) begin
    logic scl_l, sda_l;
    scl_l = !scl_oe;
    sda_l = sda_in;
    if (p_scl && !scl_l) begin
      last_high = cyc - t_rise;
      t_fall = cyc;
      if (s_pend) begin s2f = cyc - t_sst; s_pend = 1'b0; end
    end
    if (!p_scl && scl_l) begin
      last_low = cyc - t_fall;
      t_rise = cyc;
      mon_sh = {mon_sh[7:0], sda_l};
    end
    if ((sda_oe !== p_moe) && !scl_l && (cyc - t_fall < min_hold)) min_hold = cyc - t_fall;
    if (p_scl && scl_l && (sda_l != p_sda)) begin
      if (!sda_l) begin
        n_start++; last_setup = cyc - t_both; t_sst = cyc; s_pend = 1'b1;
      end else begin
        n_stop++; stop_setup = cyc - t_rise;
      end
    end
    if (scl_l && sda_l && !(p_scl && p_sda)) t_both = cyc;
    p_scl = scl_l; p_sda = sda_l; p_moe = sda_oe;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [1:0] op, input logic [7:0] d, input logic nk);
    @(negedge clk);
    while (busy) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d; cmd_nack = nk;
    @(negedge clk);
    cmd_valid = 1'b0;
    last_busy_after = busy;
    while (!done) @(negedge clk);
    @(negedge clk);
    last_done_after = done;
  endtask

  task automatic t_reset();
    check(!scl_oe && !sda_oe, "R1 lines released", {scl_oe, sda_oe}, 0);
    check(!busy && !done, "R1 busy/done", {busy, done}, 0);
  endtask

  task automatic t_start_idle();
    int ns;
    ns = n_start;
    do_cmd(2'd0, 8'h00, 1'b0);
    check(last_busy_after, "R10 busy after accept", last_busy_after, 1);
    check(n_start == ns + 1, "R2 start seen", n_start, ns + 1);
    check(s2f == int'(cfg_period >> 1), "R2 start to SCL fall", s2f, cfg_period >> 1);
    check(scl_oe && sda_oe, "R2 both low after start", {scl_oe, sda_oe}, 3);
  endtask

  task automatic t_write(input logic [7:0] d, input logic ack, input bit chk_phase);
    int ns, np;
    ns = n_start; np = n_stop; min_hold = 9999;
    fork
      do_cmd(2'd2, d, 1'b0);
      begin
        repeat (8) @(posedge scl_oe);
        tgt_oe = ack;
        @(posedge scl_oe);
        tgt_oe = 1'b0;
      end
    join
    check(mon_sh[8:1] == d, "R6 bits on bus", mon_sh[8:1], d);
    check(mon_sh[0] == !ack, "R6 ninth bit released", mon_sh[0], !ack);
    check(nack == !ack, "R6 nack flag", nack, !ack);
    check(n_start == ns && n_stop == np, "R3 no condition inside byte", n_start + n_stop, ns + np);
    check(min_hold == int'(cfg_hold), "R4 hold after fall", min_hold, cfg_hold);
    if (chk_phase) begin
      check(last_low == int'(cfg_period >> 1), "R5 low phase", last_low, cfg_period >> 1);
      check(last_high == int'(cfg_period >> 1), "R5 high phase", last_high, cfg_period >> 1);
    end
  endtask

  task automatic t_read(input logic [7:0] b, input logic nk);
    tgt_oe = ~b[7];
    fork
      do_cmd(2'd3, 8'h00, nk);
      begin
        for (int i = 1; i < 8; i++) begin
          @(posedge scl_oe);
          tgt_oe = ~b[7-i];
        end
        @(posedge scl_oe);
        tgt_oe = 1'b0;
      end
    join
    check(rd_data == b, "R7 read byte", rd_data, b);
    check(mon_sh[8:1] == b, "R7 master released during data", mon_sh[8:1], b);
    check(mon_sh[0] == nk, "R7 ninth bit answer", mon_sh[0], nk);
  endtask

  task automatic t_rstart();
    int ns, expv;
    ns = n_start;
    expv = (int'(cfg_period >> 1) > 60) ? int'(cfg_period >> 1) : 60;
    do_cmd(2'd0, 8'h00, 1'b0);
    check(n_start == ns + 1, "R8 repeated start seen", n_start, ns + 1);
    check(last_setup == expv, "R8 released time before start", last_setup, expv);
  endtask

  task automatic t_stop();
    int np;
    np = n_stop;
    do_cmd(2'd1, 8'h00, 1'b0);
    check(n_stop == np + 1, "R9 stop seen", n_stop, np + 1);
    check(stop_setup == int'(cfg_period >> 1), "R9 stop setup", stop_setup, cfg_period >> 1);
    check(!scl_oe && !sda_oe, "R9 bus released", {scl_oe, sda_oe}, 0);
  endtask

  task automatic t_busy_ignore();
    int ns, np;
    ns = n_start; np = n_stop;
    fork
      do_cmd(2'd2, 8'h0F, 1'b0);
      begin
        repeat (8) @(posedge scl_oe);
        tgt_oe = 1'b1;
        @(posedge scl_oe);
        tgt_oe = 1'b0;
      end
      begin
        repeat (60) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd1;
        @(negedge clk);
        cmd_valid = 1'b0;
      end
    join
    check(n_start == ns && n_stop == np, "R10 command while busy ignored", n_stop, np);
    check(mon_sh[8:1] == 8'h0F, "R10 byte intact", mon_sh[8:1], 8'h0F);
    check(!last_done_after, "R10 done single cycle", last_done_after, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    // period 40, hold 3
    t_start_idle();
    t_write(8'hA6, 1'b1, 1'b1);
    t_write(8'h3C, 1'b0, 1'b1);
    t_rstart();
    t_read(8'h5A, 1'b0);
    t_read(8'hC3, 1'b1);
    t_stop();
    // same-clock hold
    cfg_hold = 8'd0;
    t_start_idle();
    t_write(8'h55, 1'b1, 1'b1);
    t_busy_ignore();
    t_stop();
    // 400 kHz at 100 MHz, 60 ns hold
    cfg_period = 16'd250; cfg_hold = 8'd6;
    t_start_idle();
    t_write(8'h81, 1'b1, 1'b1);
    t_rstart();
    t_stop();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule